// File: doc/BRIEF.md
# Debug Hardware Watchpoint Unit

This block sits beside a small processor core and watches its memory traffic for a debugger. It holds one program-counter breakpoint and one data watchpoint for each of three data spaces: on-chip scratch RAM, the special-register space, and external data memory. When an armed comparator matches, the unit raises a registered halt request. The request stays up until software clears it. A one-hot source field records which comparator caused the halt. The debugger's transport layer and the core's halt sequencing sit outside this block.

Each data watchpoint has an enable bit and a two-bit mode. The mode selects write or read traffic, and selects whether the address alone is enough to fire or the data on that space's bus must also equal a stored value. Configuration is written through a plain register port. While the debugger itself is driving an access, every comparator is suppressed, so the debugger's own reads and writes cannot trip a halt.

A three-state machine sequences the unit. `ST_IDLE` means no comparator is enabled. `ST_ARMED` means at least one comparator is enabled and the unit is watching. `ST_HALTED` means a match has been caught.
- IDLE→ARMED when any enable bit becomes set.
- ARMED→IDLE when every enable bit is cleared.
- ARMED→HALTED on any comparator hit.
- HALTED→ARMED, or HALTED→IDLE, on a clear command; which one depends on whether any enable bit is still set.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset the outputs are `halt_req`=0, `halt_src`=0, `cpu_running`=1 and `dbg_busy`=0.
- R2: The PC breakpoint fires only when it is enabled, `pc_start` is high, and `pc` equals the stored breakpoint address. On the clock edge that samples the match, `halt_req` rises and `halt_src` becomes 4'b0001.
- R3: A data watchpoint in mode 0 (write) fires on any write strobe to its stored address, whatever the data.
- R4: A data watchpoint in mode 1 (read) fires on any read strobe from its stored address, whatever the data.
- R5: In mode 2 (write with data) and mode 3 (read with data), a watchpoint fires only when the strobe and the address match and the space's data bus equals the stored match value.
- R6: A disabled comparator never fires. An access to any other address never fires, including one that differs only in the top bit of the 24-bit external address.
- R7: Once raised, `halt_req` stays high until a clear command arrives. A clear command is a configuration write to index 8 with bit 0 set. After the clear, `halt_req` and `halt_src` are both 0 on the next edge. A hit in the same cycle as a clear does not re-halt.
- R8: `halt_src` is one-hot while halted: bit 0 is the PC breakpoint, bit 1 internal RAM, bit 2 the special-register space, bit 3 external memory. If several comparators hit in the same cycle, the lowest bit wins. Later hits leave the field unchanged until a clear.
- R9: While `dbg_acc` is high, no comparator can start a halt.
- R10: `cpu_running` is low exactly while halted. `dbg_busy` equals `dbg_acc` delayed by one clock.
- R11: Configuration register map:
  - Index 0: bit 0 is the PC breakpoint enable.
  - Index 1: the breakpoint address.
  - Indices 2 and 3 (internal RAM), 4 and 5 (special registers), 6 and 7 (external memory) hold, for each space, a control word and then an address.
  - Control word layout: bit 0 enable, bits 2:1 mode, bits 15:8 match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register index |
| cfg_wdata | input | CFG_W (32) | Configuration write data |
| pc | input | PC_W (16) | Current program counter |
| pc_start | input | 1 | Instruction-start strobe |
| dbg_acc | input | 1 | Debugger access in progress |
| iram_addr | input | IAW (8) | Internal RAM address |
| iram_data | input | DW (8) | Internal RAM data (write or read) |
| iram_rd | input | 1 | Internal RAM read strobe |
| iram_wr | input | 1 | Internal RAM write strobe |
| sfr_addr | input | SAW (8) | Special-register address |
| sfr_data | input | DW (8) | Special-register data |
| sfr_rd | input | 1 | Special-register read strobe |
| sfr_wr | input | 1 | Special-register write strobe |
| xmem_addr | input | XAW (24) | External memory address |
| xmem_data | input | DW (8) | External memory data |
| xmem_rd | input | 1 | External memory read strobe |
| xmem_wr | input | 1 | External memory write strobe |
| halt_req | output | 1 | Sticky halt request |
| halt_src | output | 4 | One-hot source of the halt |
| cpu_running | output | 1 | High while the core is not halted |
| dbg_busy | output | 1 | Registered debugger-access indicator |

## Verification
The bench sweeps every space, every mode and every combination of read or write, address hit or miss, and data hit or miss, and compares each result against a match predicate it computes itself. That sweep catches a design that mixes up the read and write strobes, ignores the data for the data modes, or truncates the wide external address: such a design would halt on accesses that must be ignored. Directed cases cover three hazards:
- Simultaneous hits. A design that took the highest comparator, or overwrote the source on a later hit, would report the wrong bit.
- A clear arriving together with a hit. A design that let the hit win would stay halted.
- Debugger-driven accesses. A design that did not gate the comparators would halt on the debugger's own traffic.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

    localparam int NSPACE = 3;
    localparam int NSRC   = NSPACE + 1;

    typedef enum logic [1:0] {
        WM_WRITE      = 2'd0,
        WM_READ       = 2'd1,
        WM_WRITE_DATA = 2'd2,
        WM_READ_DATA  = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_HALTED = 2'd2
    } fsm_e;

    localparam logic [3:0] IDX_BP_CTRL = 4'd0;
    localparam logic [3:0] IDX_BP_ADDR = 4'd1;
    localparam logic [3:0] IDX_WP_BASE = 4'd2;
    localparam logic [3:0] IDX_CLEAR   = 4'd8;

    localparam int CTRL_VAL_LSB = 8;

endpackage

// File: rtl/dbgw_regs.sv
module dbgw_regs
    import dbgw_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DW     = 8,
    parameter int IAW    = 8,
    parameter int SAW    = 8,
    parameter int XAW    = 24,
    parameter int MAX_AW = 24,
    parameter int CFG_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [3:0]                    cfg_sel,
    input  logic [CFG_W-1:0]              cfg_wdata,
    output logic                          bp_en,
    output logic [PC_W-1:0]               bp_addr,
    output logic [NSPACE-1:0]             wp_en,
    output logic [NSPACE-1:0][1:0]        wp_mode,
    output logic [NSPACE-1:0][DW-1:0]     wp_val,
    output logic [NSPACE-1:0][MAX_AW-1:0] wp_addr,
    output logic                          clr_cmd
);

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^cfg_wdata;

    assign clr_cmd = cfg_we && (cfg_sel == IDX_CLEAR) && cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_en   <= 1'b0;
            bp_addr <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == IDX_BP_CTRL) bp_en   <= cfg_wdata[0];
            if (cfg_sel == IDX_BP_ADDR) bp_addr <= cfg_wdata[PC_W-1:0];
        end
    end

    for (genvar k = 0; k < NSPACE; k++) begin : g_space
        localparam int          AWK      = (k == 0) ? IAW : (k == 1) ? SAW : XAW;
        localparam logic [3:0]  CTRL_IDX = IDX_WP_BASE + 4'(2 * k);
        localparam logic [3:0]  ADDR_IDX = IDX_WP_BASE + 4'(2 * k + 1);

        logic              en_q;
        logic [1:0]        mode_q;
        logic [DW-1:0]     val_q;
        logic [MAX_AW-1:0] addr_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q   <= 1'b0;
                mode_q <= 2'd0;
                val_q  <= '0;
                addr_q <= '0;
            end else if (cfg_we) begin
                if (cfg_sel == CTRL_IDX) begin
                    en_q   <= cfg_wdata[0];
                    mode_q <= cfg_wdata[2:1];
                    val_q  <= cfg_wdata[CTRL_VAL_LSB +: DW];
                end
                if (cfg_sel == ADDR_IDX) begin
                    addr_q <= MAX_AW'(cfg_wdata[AWK-1:0]);
                end
            end
        end

        assign wp_en[k]   = en_q;
        assign wp_mode[k] = mode_q;
        assign wp_val[k]  = val_q;
        assign wp_addr[k] = addr_q;
    end

endmodule

// File: rtl/dbgw_space_cmp.sv
module dbgw_space_cmp
    import dbgw_pkg::*;
#(
    parameter int MAX_AW = 24,
    parameter int DW     = 8
) (
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic [MAX_AW-1:0] ref_addr,
    input  logic [DW-1:0]     ref_val,
    input  logic [MAX_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_data,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              suppress,
    output logic              hit
);

    logic addr_eq;
    logic data_eq;
    logic raw_hit;

    assign addr_eq = (bus_addr == ref_addr);
    assign data_eq = (bus_data == ref_val);

    always_comb begin
        unique case (wmode_e'(mode))
            WM_WRITE:      raw_hit = bus_wr && addr_eq;
            WM_READ:       raw_hit = bus_rd && addr_eq;
            WM_WRITE_DATA: raw_hit = bus_wr && addr_eq && data_eq;
            WM_READ_DATA:  raw_hit = bus_rd && addr_eq && data_eq;
            default:       raw_hit = 1'b0;
        endcase
    end

    assign hit = en && !suppress && raw_hit;

endmodule

// File: rtl/dbgw_ctrl.sv
module dbgw_ctrl
    import dbgw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any_en,
    input  logic [NSRC-1:0] hits,
    input  logic            clr_cmd,
    input  logic            dbg_acc,
    output logic            halt_req,
    output logic [NSRC-1:0] halt_src,
    output logic            cpu_running,
    output logic            dbg_busy
);

    fsm_e            state_q;
    fsm_e            state_d;
    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] first_hit;
    logic            dbg_q;

    assign first_hit = hits & (~hits + NSRC'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (any_en) state_d = ST_ARMED;
            ST_ARMED: begin
                if (|hits)        state_d = ST_HALTED;
                else if (!any_en) state_d = ST_IDLE;
            end
            ST_HALTED: if (clr_cmd) state_d = any_en ? ST_ARMED : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= '0;
            dbg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dbg_q   <= dbg_acc;
            if (state_q == ST_HALTED && clr_cmd)
                src_q <= '0;
            else if (state_q == ST_ARMED && (|hits))
                src_q <= first_hit;
        end
    end

    always_comb begin
        halt_req    = (state_q == ST_HALTED);
        cpu_running = (state_q != ST_HALTED);
        halt_src    = src_q;
        dbg_busy    = dbg_q;
    end

endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
    import dbgw_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int DW    = 8,
    parameter int IAW   = 8,
    parameter int SAW   = 8,
    parameter int XAW   = 24,
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [PC_W-1:0]  pc,
    input  logic             pc_start,
    input  logic             dbg_acc,
    input  logic [IAW-1:0]   iram_addr,
    input  logic [DW-1:0]    iram_data,
    input  logic             iram_rd,
    input  logic             iram_wr,
    input  logic [SAW-1:0]   sfr_addr,
    input  logic [DW-1:0]    sfr_data,
    input  logic             sfr_rd,
    input  logic             sfr_wr,
    input  logic [XAW-1:0]   xmem_addr,
    input  logic [DW-1:0]    xmem_data,
    input  logic             xmem_rd,
    input  logic             xmem_wr,
    output logic             halt_req,
    output logic [NSRC-1:0]  halt_src,
    output logic             cpu_running,
    output logic             dbg_busy
);

    localparam int AW01   = (IAW > SAW) ? IAW : SAW;
    localparam int MAX_AW = (AW01 > XAW) ? AW01 : XAW;

    logic                          bp_en;
    logic [PC_W-1:0]               bp_addr;
    logic [NSPACE-1:0]             wp_en;
    logic [NSPACE-1:0][1:0]        wp_mode;
    logic [NSPACE-1:0][DW-1:0]     wp_val;
    logic [NSPACE-1:0][MAX_AW-1:0] wp_addr;
    logic                          clr_cmd;

    logic [NSPACE-1:0][MAX_AW-1:0] bus_addr;
    logic [NSPACE-1:0][DW-1:0]     bus_data;
    logic [NSPACE-1:0]             bus_rd;
    logic [NSPACE-1:0]             bus_wr;
    logic [NSPACE-1:0]             wp_hit;
    logic                          pc_hit;
    logic                          any_en;

    assign bus_addr[0] = MAX_AW'(iram_addr);
    assign bus_addr[1] = MAX_AW'(sfr_addr);
    assign bus_addr[2] = MAX_AW'(xmem_addr);
    assign bus_data    = {xmem_data, sfr_data, iram_data};
    assign bus_rd      = {xmem_rd, sfr_rd, iram_rd};
    assign bus_wr      = {xmem_wr, sfr_wr, iram_wr};

    dbgw_regs #(
        .PC_W(PC_W), .DW(DW), .IAW(IAW), .SAW(SAW), .XAW(XAW),
        .MAX_AW(MAX_AW), .CFG_W(CFG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .bp_en(bp_en), .bp_addr(bp_addr),
        .wp_en(wp_en), .wp_mode(wp_mode), .wp_val(wp_val), .wp_addr(wp_addr),
        .clr_cmd(clr_cmd)
    );

    assign pc_hit = bp_en && pc_start && !dbg_acc && (pc == bp_addr);

    for (genvar k = 0; k < NSPACE; k++) begin : g_cmp
        dbgw_space_cmp #(.MAX_AW(MAX_AW), .DW(DW)) u_cmp (
            .en(wp_en[k]), .mode(wp_mode[k]),
            .ref_addr(wp_addr[k]), .ref_val(wp_val[k]),
            .bus_addr(bus_addr[k]), .bus_data(bus_data[k]),
            .bus_rd(bus_rd[k]), .bus_wr(bus_wr[k]),
            .suppress(dbg_acc), .hit(wp_hit[k])
        );
    end

    assign any_en = bp_en || (|wp_en);

    dbgw_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .any_en(any_en), .hits({wp_hit, pc_hit}),
        .clr_cmd(clr_cmd), .dbg_acc(dbg_acc),
        .halt_req(halt_req), .halt_src(halt_src),
        .cpu_running(cpu_running), .dbg_busy(dbg_busy)
    );

endmodule

// File: rtl/dbgw_chk.sv
module dbgw_chk #(
    parameter int CFG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [3:0]       cfg_sel,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             pc_start,
    input logic             dbg_acc,
    input logic             iram_rd,
    input logic             iram_wr,
    input logic             sfr_rd,
    input logic             sfr_wr,
    input logic             xmem_rd,
    input logic             xmem_wr,
    input logic             halt_req,
    input logic [3:0]       halt_src,
    input logic             cpu_running,
    input logic             dbg_busy
);

    logic clr_seen;
    logic bus_quiet;
    assign clr_seen  = cfg_we && (cfg_sel == 4'd8) && cfg_wdata[0];
    assign bus_quiet = !pc_start && !iram_rd && !iram_wr && !sfr_rd && !sfr_wr
                       && !xmem_rd && !xmem_wr;

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req && !clr_seen |=> halt_req);

    // R7
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req && clr_seen |=> !halt_req && (halt_src == 4'd0));

    // R8
    src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> $countones(halt_src) == 1);

    // R8
    src_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req && !clr_seen |=> $stable(halt_src));

    // R9
    dbg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_req && dbg_acc |=> !halt_req);

    // R2
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_req && bus_quiet |=> !halt_req);

    // R10
    running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_running != halt_req);

    // R10
    busy_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> dbg_busy == $past(dbg_acc));

endmodule

bind dbg_watch_unit dbgw_chk #(.CFG_W(CFG_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pc_start(pc_start), .dbg_acc(dbg_acc),
    .iram_rd(iram_rd), .iram_wr(iram_wr),
    .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
    .xmem_rd(xmem_rd), .xmem_wr(xmem_wr),
    .halt_req(halt_req), .halt_src(halt_src),
    .cpu_running(cpu_running), .dbg_busy(dbg_busy)
);

// File: tb/sim_dbg_watch_unit.sv
`timescale 1ns/1ps
module sim_dbg_watch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] pc = '0;
    logic        pc_start = 1'b0;
    logic        dbg_acc = 1'b0;
    logic [7:0]  iram_addr = '0, iram_data = '0;
    logic        iram_rd = 1'b0, iram_wr = 1'b0;
    logic [7:0]  sfr_addr = '0, sfr_data = '0;
    logic        sfr_rd = 1'b0, sfr_wr = 1'b0;
    logic [23:0] xmem_addr = '0;
    logic [7:0]  xmem_data = '0;
    logic        xmem_rd = 1'b0, xmem_wr = 1'b0;
    logic        halt_req, cpu_running, dbg_busy;
    logic [3:0]  halt_src;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_watch_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .pc(pc), .pc_start(pc_start), .dbg_acc(dbg_acc),
        .iram_addr(iram_addr), .iram_data(iram_data), .iram_rd(iram_rd), .iram_wr(iram_wr),
        .sfr_addr(sfr_addr), .sfr_data(sfr_data), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
        .xmem_addr(xmem_addr), .xmem_data(xmem_data), .xmem_rd(xmem_rd), .xmem_wr(xmem_wr),
        .halt_req(halt_req), .halt_src(halt_src), .cpu_running(cpu_running), .dbg_busy(dbg_busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic [3:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    endtask

    task automatic bus_idle();
        pc_start = 1'b0;
        iram_rd = 1'b0; iram_wr = 1'b0;
        sfr_rd = 1'b0; sfr_wr = 1'b0;
        xmem_rd = 1'b0; xmem_wr = 1'b0;
    endtask

    // Sets up one space access; caller advances the clock.
    task automatic set_access(input int k, input bit rd, input logic [23:0] a, input logic [7:0] d);
        case (k)
            0: begin iram_addr = a[7:0]; iram_data = d; iram_rd = rd; iram_wr = !rd; end
            1: begin sfr_addr = a[7:0];  sfr_data = d;  sfr_rd = rd;  sfr_wr = !rd;  end
            default: begin xmem_addr = a; xmem_data = d; xmem_rd = rd; xmem_wr = !rd; end
        endcase
    endtask

    task automatic one_access(input int k, input bit rd, input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        set_access(k, rd, a, d);
        @(negedge clk);
        bus_idle();
    endtask

    function automatic logic [23:0] space_addr(input int k);
        case (k)
            0: return 24'h00005A;
            1: return 24'h0000A3;
            default: return 24'h123456;
        endcase
    endfunction

    function automatic logic [23:0] miss_addr(input int k);
        if (k == 2) return 24'h923456;
        return space_addr(k) ^ 24'h000001;
    endfunction

    localparam logic [7:0] MV = 8'hC3;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(halt_req == 1'b0, "R1", "halt_req", 32'(halt_req), 0);
        chk(halt_src == 4'd0, "R1", "halt_src", 32'(halt_src), 0);
        chk(cpu_running == 1'b1, "R1", "cpu_running", 32'(cpu_running), 1);
        chk(dbg_busy == 1'b0, "R1", "dbg_busy", 32'(dbg_busy), 0);

        // R3 R4 R5 R6 R11: sweep spaces x modes x access kinds
        for (int k = 0; k < 3; k++) begin
            cfg(4'(3 + 2 * k), {8'h0, space_addr(k)});
            for (int m = 0; m < 4; m++) begin
                cfg(4'(2 + 2 * k), {16'h0, MV, 5'h0, 2'(m), 1'b1});
                for (int c = 0; c < 8; c++) begin
                    bit rd = c[0];
                    bit am = c[1];
                    bit dm = c[2];
                    bit fire = am && (rd == m[0]) && (m < 2 || dm);
                    one_access(k, rd, am ? space_addr(k) : miss_addr(k), dm ? MV : (MV ^ 8'h10));
                    chk(halt_req == fire, (m < 2) ? (m == 0 ? "R3" : "R4") : "R5",
                        $sformatf("halt space=%0d mode=%0d case=%0d", k, m, c),
                        32'(halt_req), 32'(fire));
                    chk(halt_src == (fire ? 4'(1 << (k + 1)) : 4'd0), "R8",
                        $sformatf("src space=%0d mode=%0d case=%0d", k, m, c),
                        32'(halt_src), fire ? 32'(1 << (k + 1)) : 0);
                    cfg(4'd8, 32'h1);
                end
            end
            cfg(4'(2 + 2 * k), 32'h0);
        end

        // R6 disabled comparator ignores a matching access
        cfg(4'd3, 32'h5A);
        cfg(4'd2, {16'h0, MV, 8'h00});
        one_access(0, 1'b0, 24'h5A, MV);
        chk(halt_req == 1'b0, "R6", "disabled watchpoint", 32'(halt_req), 0);

        // R2 PC breakpoint
        cfg(4'd1, 32'h1234);
        cfg(4'd0, 32'h1);
        @(negedge clk); pc = 16'h1234; pc_start = 1'b0;
        @(negedge clk); bus_idle();
        chk(halt_req == 1'b0, "R2", "no strobe", 32'(halt_req), 0);
        @(negedge clk); pc = 16'h1235; pc_start = 1'b1;
        @(negedge clk); bus_idle();
        chk(halt_req == 1'b0, "R2", "wrong pc", 32'(halt_req), 0);
        @(negedge clk); pc = 16'h1234; pc_start = 1'b1;
        @(negedge clk); bus_idle();
        chk(halt_req == 1'b1, "R2", "pc hit", 32'(halt_req), 1);
        chk(halt_src == 4'b0001, "R2", "pc src", 32'(halt_src), 1);
        chk(cpu_running == 1'b0, "R10", "running while halted", 32'(cpu_running), 0);

        // R7 sticky across idle cycles, then clear
        repeat (5) @(negedge clk);
        chk(halt_req == 1'b1, "R7", "sticky", 32'(halt_req), 1);
        cfg(4'd8, 32'h1);
        chk(halt_req == 1'b0 && halt_src == 4'd0, "R7", "after clear",
            {halt_src, 3'b0, halt_req}, 0);
        chk(cpu_running == 1'b1, "R10", "running after clear", 32'(cpu_running), 1);

        // R8 simultaneous internal RAM and external hits: lowest wins, sticky vs later PC hit
        cfg(4'd2, {16'h0, MV, 8'h01});
        cfg(4'd7, 32'h123456);
        cfg(4'd6, {16'h0, MV, 8'h01});
        @(negedge clk);
        set_access(0, 1'b0, 24'h5A, 8'h00);
        set_access(2, 1'b0, 24'h123456, 8'h00);
        @(negedge clk); bus_idle();
        chk(halt_src == 4'b0010, "R8", "simultaneous", 32'(halt_src), 32'h2);
        @(negedge clk); pc = 16'h1234; pc_start = 1'b1;
        @(negedge clk); bus_idle();
        chk(halt_src == 4'b0010, "R8", "later hit ignored", 32'(halt_src), 32'h2);

        // R7 clear with a hit in the same cycle does not re-halt
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'd8; cfg_wdata = 32'h1;
        pc = 16'h1234; pc_start = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; bus_idle();
        chk(halt_req == 1'b0, "R7", "clear beats hit", 32'(halt_req), 0);

        // R8 PC plus both data hits: PC wins
        @(negedge clk);
        pc_start = 1'b1;
        set_access(0, 1'b0, 24'h5A, 8'h00);
        set_access(2, 1'b0, 24'h123456, 8'h00);
        @(negedge clk); bus_idle();
        chk(halt_src == 4'b0001, "R8", "pc priority", 32'(halt_src), 1);
        cfg(4'd8, 32'h1);

        // R9 R10 debugger access suppresses hits and shows on dbg_busy
        @(negedge clk);
        dbg_acc = 1'b1; pc_start = 1'b1;
        set_access(0, 1'b0, 24'h5A, 8'h00);
        @(negedge clk); bus_idle();
        chk(halt_req == 1'b0, "R9", "debugger access", 32'(halt_req), 0);
        chk(dbg_busy == 1'b1, "R10", "busy high", 32'(dbg_busy), 1);
        dbg_acc = 1'b0;
        @(negedge clk);
        chk(dbg_busy == 1'b0, "R10", "busy low", 32'(dbg_busy), 0);
        one_access(0, 1'b0, 24'h5A, 8'h00);
        chk(halt_req == 1'b1, "R9", "hit after debugger access", 32'(halt_req), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule